// File: doc/BRIEF.md
# Per-Thread Circular Return Stack

This unit is the return stack of a small stack processor that runs several threads. It holds a 10-bit stack pointer and shows the two newest stack entries on output ports on every cycle. The entries live in one synchronous memory of 1024 words of 32 bits. The upper five pointer bits pick one of 32 regions, one region for each thread. Each region of 32 words is a circular stack. Push and drop change only the lower five pointer bits, so a thread that pushes past its region's end, or pops below its start, wraps around inside its own region. It never spills into another thread's region.

The newest entry is kept in a register. The entry below it is read from memory through a read port that is always addressed with the pointer value for the next cycle. A second read port is addressed one slot lower, so that a two-item drop can reload the top from the third entry in a single cycle. A 7-bit command selects idle, pointer load, push, drop one or drop two. During a drop cycle, the outputs still show the values that are being removed, so the controller can consume them before they go.

Top module: `thread_rstack`

## Requirements
- R1: While reset is asserted, and after it is released, the pointer output and the top-entry output are both zero until the first command other than idle is applied.
- R2: Push (command code 0x02) makes the top output equal to the data input, makes the second output equal to the previous top, and advances the lower five pointer bits by one.
- R3: Push, drop-one and drop-two never change the upper five pointer bits (the region).
- R4: The lower five pointer bits wrap modulo 32: push from slot 31 gives slot 0, drop-one from slot 0 gives slot 31, drop-two from slot 1 gives slot 31, and drop-two from slot 0 gives slot 30.
- R5: Drop-one (code 0x04) moves the previous second entry into the top output and lowers the slot by one. The old top stays visible on the top output during the command's own cycle.
- R6: Drop-two (code 0x08) moves the third entry into the top output, makes the second output the fourth entry, and lowers the slot by two. The old top stays visible during the command's own cycle.
- R7: Pointer load (code 0x01) copies the full 10-bit load input into the pointer and leaves the top entry unchanged. On the next cycle the second output shows the memory word at the new pointer.
- R8: Idle (code 0x00) and every other code change neither the pointer nor the top or second outputs.
- R9: Pushes in one region leave the contents of every other region intact.
- R10: The block recognises only the five command codes 0x00, 0x01, 0x02, 0x04 and 0x08, compared as full 7-bit values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; asserts asynchronously, is released synchronously inside the block |
| cmd_i | input | 7 | Stack command code |
| data_i | input | 32 | Value pushed by a push command |
| sp_load_i | input | 10 | New pointer value used by a load command |
| sp_o | output | 10 | Current pointer: region in bits 9:5, slot in bits 4:0 |
| tos_o | output | 32 | Newest stack entry |
| nos_o | output | 32 | Entry just below the newest |

## Verification
The bound checker looks at every cycle. It checks that the region bits survive push and drops, that the slot steps by +1, -1 and -2, that a push moves the data input and the old top to the right outputs, that a drop-one promotes the second entry, that a load copies the pointer and keeps the top, and that idle or unknown codes hold all three outputs. Only the bench scenarios can show the things that depend on memory contents from earlier cycles. These are the third entry returned by a drop-two, the second output after a load into a region written long before, the survival of one region's data while another region is pushed, and the wraps at slots 0, 1 and 31 with known data.

// File: rtl/rstk_pkg.sv
package rstk_pkg;
  localparam int CMD_W = 7;

  typedef enum logic [CMD_W-1:0] {
    CMD_IDLE  = 7'h00,
    CMD_LOAD  = 7'h01,
    CMD_PUSH  = 7'h02,
    CMD_DROP1 = 7'h04,
    CMD_DROP2 = 7'h08
  } cmd_e;

  // Any code outside the legal set behaves as idle.
  function automatic cmd_e cmd_decode(input logic [CMD_W-1:0] raw);
    cmd_e res;
    case (raw)
      7'h01:   res = CMD_LOAD;
      7'h02:   res = CMD_PUSH;
      7'h04:   res = CMD_DROP1;
      7'h08:   res = CMD_DROP2;
      default: res = CMD_IDLE;
    endcase
    return res;
  endfunction
endpackage

// File: rtl/rstk_ptr_next.sv
module rstk_ptr_next
  import rstk_pkg::*;
#(
  parameter int REGION_BITS = 5,
  parameter int SLOT_BITS   = 5,
  localparam int PTR_W      = REGION_BITS + SLOT_BITS
) (
  input  cmd_e             cmd,
  input  logic [PTR_W-1:0] sp,
  input  logic [PTR_W-1:0] sp_load,
  output logic [PTR_W-1:0] sp_next,
  output logic [PTR_W-1:0] sp_below
);
  logic [REGION_BITS-1:0] region;
  logic [SLOT_BITS-1:0]   slot;
  logic [SLOT_BITS-1:0]   slot_inc;
  logic [SLOT_BITS-1:0]   slot_dec1;
  logic [SLOT_BITS-1:0]   slot_dec2;
  logic [SLOT_BITS-1:0]   next_slot;

  assign region    = sp[PTR_W-1:SLOT_BITS];
  assign slot      = sp[SLOT_BITS-1:0];
  assign slot_inc  = slot + SLOT_BITS'(1);
  assign slot_dec1 = slot - SLOT_BITS'(1);
  assign slot_dec2 = slot - SLOT_BITS'(2);

  always_comb begin
    case (cmd)
      CMD_LOAD:  sp_next = sp_load;
      CMD_PUSH:  sp_next = {region, slot_inc};
      CMD_DROP1: sp_next = {region, slot_dec1};
      CMD_DROP2: sp_next = {region, slot_dec2};
      default:   sp_next = sp;
    endcase
  end

  assign next_slot = sp_next[SLOT_BITS-1:0] - SLOT_BITS'(1);
  assign sp_below  = {sp_next[PTR_W-1:SLOT_BITS], next_slot};
endmodule

// File: rtl/rstk_ram.sv
module rstk_ram #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 10,
  parameter int NRD    = 2,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic                           clk,
  input  logic                           we,
  input  logic [ADDR_W-1:0]              waddr,
  input  logic [DATA_W-1:0]              wdata,
  input  logic [NRD-1:0][ADDR_W-1:0]     raddr,
  output logic [NRD-1:0][DATA_W-1:0]     rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
  end

  // Each read port registers its word; a same-edge write is forwarded.
  for (genvar r = 0; r < NRD; r++) begin : g_rd
    always_ff @(posedge clk) begin
      if (we && (waddr == raddr[r])) begin
        rdata[r] <= wdata;
      end else begin
        rdata[r] <= mem[raddr[r]];
      end
    end
  end
endmodule

// File: rtl/thread_rstack.sv
module thread_rstack
  import rstk_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int REGION_BITS = 5,
  parameter int SLOT_BITS   = 5,
  localparam int PTR_W      = REGION_BITS + SLOT_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CMD_W-1:0]  cmd_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [PTR_W-1:0]  sp_load_i,
  output logic [PTR_W-1:0]  sp_o,
  output logic [DATA_W-1:0] tos_o,
  output logic [DATA_W-1:0] nos_o
);
  localparam int NRD = 2;

  logic [1:0]               rst_sync_q;
  logic                     rst_int_n;
  cmd_e                     cmd;
  logic [PTR_W-1:0]         sp_q;
  logic [PTR_W-1:0]         sp_next;
  logic [PTR_W-1:0]         sp_below;
  logic                     sp_en;
  logic [DATA_W-1:0]        tos_q;
  logic [DATA_W-1:0]        tos_next;
  logic                     tos_en;
  logic                     ram_we;
  logic [NRD-1:0][PTR_W-1:0]  rd_addr;
  logic [NRD-1:0][DATA_W-1:0] rd_data;

  // Reset asserts at once and is released two edges later.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  assign cmd = rst_int_n ? cmd_decode(cmd_i) : CMD_IDLE;

  rstk_ptr_next #(
    .REGION_BITS(REGION_BITS),
    .SLOT_BITS  (SLOT_BITS)
  ) u_ptr (
    .cmd     (cmd),
    .sp      (sp_q),
    .sp_load (sp_load_i),
    .sp_next (sp_next),
    .sp_below(sp_below)
  );

  // Next-state logic
  always_comb begin
    sp_en    = (cmd != CMD_IDLE);
    tos_en   = 1'b1;
    tos_next = tos_q;
    case (cmd)
      CMD_PUSH:  tos_next = data_i;
      CMD_DROP1: tos_next = rd_data[0];
      CMD_DROP2: tos_next = rd_data[1];
      default:   tos_en   = 1'b0;
    endcase
  end

  // State registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      sp_q <= '0;
    end else if (sp_en) begin
      sp_q <= sp_next;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      tos_q <= '0;
    end else if (tos_en) begin
      tos_q <= tos_next;
    end
  end

  // A push spills the old top into the slot the pointer moves to.
  assign ram_we     = (cmd == CMD_PUSH);
  assign rd_addr[0] = sp_next;
  assign rd_addr[1] = sp_below;

  rstk_ram #(
    .DATA_W(DATA_W),
    .ADDR_W(PTR_W),
    .NRD   (NRD)
  ) u_ram (
    .clk  (clk),
    .we   (ram_we),
    .waddr(sp_next),
    .wdata(tos_q),
    .raddr(rd_addr),
    .rdata(rd_data)
  );

  assign sp_o  = sp_q;
  assign tos_o = tos_q;
  assign nos_o = rd_data[0];
endmodule

// File: rtl/thread_rstack_chk.sv
module thread_rstack_chk
  import rstk_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int REGION_BITS = 5,
  parameter int SLOT_BITS   = 5,
  localparam int PTR_W      = REGION_BITS + SLOT_BITS
) (
  input logic              clk,
  input logic              rst_n,
  input logic [CMD_W-1:0]  cmd_i,
  input logic [DATA_W-1:0] data_i,
  input logic [PTR_W-1:0]  sp_load_i,
  input logic [PTR_W-1:0]  sp_o,
  input logic [DATA_W-1:0] tos_o,
  input logic [DATA_W-1:0] nos_o
);
  cmd_e c;
  assign c = cmd_decode(cmd_i);

  AST_REGION_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (c == CMD_PUSH || c == CMD_DROP1 || c == CMD_DROP2) |=>
      sp_o[PTR_W-1:SLOT_BITS] == $past(sp_o[PTR_W-1:SLOT_BITS])); // R3

  AST_PUSH_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (c == CMD_PUSH) |=>
      sp_o[SLOT_BITS-1:0] == $past(sp_o[SLOT_BITS-1:0]) + SLOT_BITS'(1)); // R4

  AST_DROP1_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (c == CMD_DROP1) |=>
      sp_o[SLOT_BITS-1:0] == $past(sp_o[SLOT_BITS-1:0]) - SLOT_BITS'(1)); // R5

  AST_DROP2_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (c == CMD_DROP2) |=>
      sp_o[SLOT_BITS-1:0] == $past(sp_o[SLOT_BITS-1:0]) - SLOT_BITS'(2)); // R6

  AST_PUSH_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (c == CMD_PUSH) |=> (tos_o == $past(data_i)) && (nos_o == $past(tos_o))); // R2

  AST_DROP1_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (c == CMD_DROP1) |=> tos_o == $past(nos_o)); // R5

  AST_LOAD_PTR: assert property (@(posedge clk) disable iff (!rst_n)
    (c == CMD_LOAD) |=> (sp_o == $past(sp_load_i)) && (tos_o == $past(tos_o))); // R7

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (c == CMD_IDLE) |=> $stable(sp_o) && $stable(tos_o) && $stable(nos_o)); // R8
endmodule

bind thread_rstack thread_rstack_chk #(
  .DATA_W     (DATA_W),
  .REGION_BITS(REGION_BITS),
  .SLOT_BITS  (SLOT_BITS)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_int_n),
  .cmd_i    (cmd_i),
  .data_i   (data_i),
  .sp_load_i(sp_load_i),
  .sp_o     (sp_o),
  .tos_o    (tos_o),
  .nos_o    (nos_o)
);

// File: tb/thread_rstack_tb.sv
`timescale 1ns/1ps
module thread_rstack_tb;
  localparam int NV = 16;
  localparam int VW = 7 + 32 + 10 + 10 + 32 + 32 + 1;

  typedef struct packed {
    logic [6:0]  cmd;
    logic [31:0] data;
    logic [9:0]  ld;
    logic [9:0]  esp;
    logic [31:0] etos;
    logic [31:0] enos;
    logic        cn;
  } vec_t;

  // cmd, data, load, expected sp, expected top, expected second, check second
  localparam logic [VW-1:0] VEC [NV] = '{
    {7'h01, 32'h0,  10'h0A0, 10'h0A0, 32'h0,  32'h0,  1'b0},
    {7'h02, 32'h11, 10'h0,   10'h0A1, 32'h11, 32'h0,  1'b1},
    {7'h02, 32'h22, 10'h0,   10'h0A2, 32'h22, 32'h11, 1'b1},
    {7'h02, 32'h33, 10'h0,   10'h0A3, 32'h33, 32'h22, 1'b1},
    {7'h00, 32'h5A, 10'h3FF, 10'h0A3, 32'h33, 32'h22, 1'b1},
    {7'h03, 32'h5A, 10'h3FF, 10'h0A3, 32'h33, 32'h22, 1'b1},
    {7'h04, 32'h0,  10'h0,   10'h0A2, 32'h22, 32'h11, 1'b1},
    {7'h02, 32'h44, 10'h0,   10'h0A3, 32'h44, 32'h22, 1'b1},
    {7'h08, 32'h0,  10'h0,   10'h0A1, 32'h11, 32'h0,  1'b1},
    {7'h02, 32'h55, 10'h0,   10'h0A2, 32'h55, 32'h11, 1'b1},
    {7'h01, 32'h0,  10'h3E0, 10'h3E0, 32'h55, 32'h0,  1'b0},
    {7'h02, 32'h66, 10'h0,   10'h3E1, 32'h66, 32'h55, 1'b1},
    {7'h01, 32'h0,  10'h0A2, 10'h0A2, 32'h66, 32'h11, 1'b1},
    {7'h04, 32'h0,  10'h0,   10'h0A1, 32'h11, 32'h0,  1'b1},
    {7'h7F, 32'h99, 10'h3FF, 10'h0A1, 32'h11, 32'h0,  1'b1},
    {7'h10, 32'h99, 10'h3FF, 10'h0A1, 32'h11, 32'h0,  1'b1}
  };

  logic        clk;
  logic        rst_n;
  logic [6:0]  cmd_i;
  logic [31:0] data_i;
  logic [9:0]  sp_load_i;
  logic [9:0]  sp_o;
  logic [31:0] tos_o;
  logic [31:0] nos_o;

  int checks;
  int errors;
  bit done;

  thread_rstack u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_i    (cmd_i),
    .data_i   (data_i),
    .sp_load_i(sp_load_i),
    .sp_o     (sp_o),
    .tos_o    (tos_o),
    .nos_o    (nos_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [6:0] c);
    case (c)
      7'h01:   return "R7 R9 R10";
      7'h02:   return "R2 R3 R10";
      7'h04:   return "R5 R3 R10";
      7'h08:   return "R6 R3 R10";
      default: return "R8 R10";
    endcase
  endfunction

  // Drive at a falling edge, let one rising edge pass, sample at the next falling edge.
  task automatic step(input logic [6:0] c, input logic [31:0] d, input logic [9:0] ld);
    cmd_i     = c;
    data_i    = d;
    sp_load_i = ld;
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    cmd_i = 7'h00;
    #1;
    check("R1 sp during reset", {22'h0, sp_o}, 32'h0);
    check("R1 top during reset", tos_o, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 sp after release", {22'h0, sp_o}, 32'h0);
    check("R1 top after release", tos_o, 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    checks    = 0;
    errors    = 0;
    done      = 1'b0;
    rst_n     = 1'b0;
    cmd_i     = 7'h00;
    data_i    = '0;
    sp_load_i = '0;
    repeat (3) @(negedge clk);
    do_reset();

    // Table walk
    for (int i = 0; i < NV; i++) begin
      vec_t v;
      logic [31:0] prev_top;
      v = vec_t'(VEC[i]);
      prev_top = tos_o;
      cmd_i     = v.cmd;
      data_i    = v.data;
      sp_load_i = v.ld;
      #1;
      if (v.cmd == 7'h04 || v.cmd == 7'h08)
        check({tag_of(v.cmd), " old top visible"}, tos_o, prev_top);
      @(negedge clk);
      check({tag_of(v.cmd), " sp"}, {22'h0, sp_o}, {22'h0, v.esp});
      check({tag_of(v.cmd), " top"}, tos_o, v.etos);
      if (v.cn) check({tag_of(v.cmd), " second"}, nos_o, v.enos);
    end

    // Mid-run reset returns to zero state
    do_reset();

    // Wrap corners inside region 16
    step(7'h01, 32'h0, 10'h21E);
    check("R4 load", {22'h0, sp_o}, 32'h21E);
    step(7'h02, 32'h1, 10'h0);
    check("R4 push to 31 sp", {22'h0, sp_o}, 32'h21F);
    step(7'h02, 32'h2, 10'h0);
    check("R4 push wrap 31->0 sp", {22'h0, sp_o}, 32'h200);
    check("R4 push wrap second", nos_o, 32'h1);
    step(7'h02, 32'h3, 10'h0);
    check("R4 push to 1 sp", {22'h0, sp_o}, 32'h201);
    step(7'h08, 32'h0, 10'h0);
    check("R4 drop2 wrap 1->31 sp", {22'h0, sp_o}, 32'h21F);
    check("R4 drop2 wrap top", tos_o, 32'h1);
    check("R4 drop2 wrap second", nos_o, 32'h0);
    step(7'h02, 32'h4, 10'h0);
    check("R4 push again sp", {22'h0, sp_o}, 32'h200);
    step(7'h04, 32'h0, 10'h0);
    check("R4 drop1 wrap 0->31 sp", {22'h0, sp_o}, 32'h21F);
    check("R4 drop1 wrap top", tos_o, 32'h1);
    check("R4 drop1 wrap second", nos_o, 32'h0);
    step(7'h01, 32'h0, 10'h200);
    step(7'h08, 32'h0, 10'h0);
    check("R4 drop2 wrap 0->30 sp", {22'h0, sp_o}, 32'h21E);
    check("R4 drop2 wrap 0->30 top", tos_o, 32'h0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule